// File: doc/BRIEF.md
# Trace Status Port Output Controller

This block sits between the processor pipeline and the pins that an external debug probe watches. Each cycle it registers a 4-bit pipeline status code and a 4-bit debug data nibble onto the trace outputs. It also produces an enable for the trace sample clock and a halt flag. The status reflects what the pipeline is doing, not what the bus is doing. The probe samples both nibbles on the rising edge of the trace clock. That edge is generated downstream from the enable and is centred in the valid window.

After reset the sample clock stays quiet until the pipeline reports a start-up code: 0xC, 0xD or 0xF. From then on the clock is armed until the next reset. A quiescence control input freezes the trace outputs. While it is set, the status and data nibbles keep their last driven values and the clock enable is forced low. Breakpoint logic elsewhere is not affected. Clearing the control resumes normal output, and the probe then has to resynchronise.

Top module: `trace_port_ctl`

## Requirements
- R1: While rst_n is low, status_out and data_out are 4'h0, and tclk_en and halted are 0.
- R2: When quiet is 0 at a rising clock edge, status_out shows that edge's status_in from then until the next edge.
- R3: When quiet is 0 at a rising clock edge, data_out shows that edge's data_in from then until the next edge.
- R4: Before any start-up code has been seen since reset, tclk_en is 0. The start-up codes are status_in values 4'hC, 4'hD and 4'hF. When quiet is 0 at the edge where a start-up code is registered, tclk_en rises in that same cycle, along with the code on status_out.
- R5: Status codes other than the start-up codes that arrive before start-up still appear on status_out, and tclk_en stays 0.
- R6: Once armed, tclk_en is 1 after every edge where quiet is 0, whatever the status code.
- R7: When quiet is 1 at an edge, status_out and data_out keep their previous values and tclk_en is 0 after that edge.
- R8: A start-up code that arrives while quiet is 1 still arms the clock. After quiet returns to 0, tclk_en is 1 even if no further start-up code arrives.
- R9: halted is 1 exactly when status_out is 4'hF. It follows the frozen value while quiet is 1.
- R10: Asserting rst_n low after start-up disarms the clock. A new start-up code is needed before tclk_en rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_in | input | 4 | Pipeline status code for this cycle |
| data_in | input | 4 | Debug data nibble for this cycle |
| quiet | input | 1 | Freeze trace outputs and gate the clock enable |
| status_out | output | 4 | Registered status nibble toward the probe |
| data_out | output | 4 | Registered data nibble toward the probe |
| tclk_en | output | 1 | Enable for the trace sample clock |
| halted | output | 1 | AND of the four status_out bits |

## Verification
The hardest case to reach is a start-up code that arrives while the outputs are frozen. In that case the arming is invisible at the ports until quiet is cleared, and it only shows if no other start-up code follows. A directed sequence places 0xD under quiet, then drops quiet and feeds only non-start codes, so that tclk_en can only rise from the remembered arming. Random traffic then keeps start-up codes rare and toggles quiet in bursts. A mid-run reset checks that the arming is lost.

// File: rtl/trace_port_ctl.sv
module trace_port_ctl #(
  parameter int W      = 4,
  parameter logic [W-1:0] CODE_A = 4'hC,
  parameter logic [W-1:0] CODE_B = 4'hD,
  parameter logic [W-1:0] CODE_C = 4'hF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_in,
  input  logic [W-1:0] data_in,
  input  logic         quiet,
  output logic [W-1:0] status_out,
  output logic [W-1:0] data_out,
  output logic         tclk_en,
  output logic         halted
);
  logic armed;
  logic is_start;
  logic armed_nxt;

  assign is_start  = (status_in == CODE_A) || (status_in == CODE_B) || (status_in == CODE_C);
  assign armed_nxt = armed | is_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      status_out <= '0;
      data_out   <= '0;
      tclk_en    <= 1'b0;
    end else begin
      armed   <= armed_nxt;
      tclk_en <= !quiet && armed_nxt;
      if (!quiet) begin
        status_out <= status_in;
        data_out   <= data_in;
      end
    end
  end

  assign halted = &status_out;
endmodule

module trace_port_ctl_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] status_in,
  input logic [W-1:0] data_in,
  input logic         quiet,
  input logic [W-1:0] status_out,
  input logic [W-1:0] data_out,
  input logic         tclk_en,
  input logic         halted
);
  // R2
  pass_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !quiet |=> status_out == $past(status_in));
  // R3
  pass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !quiet |=> data_out == $past(data_in));
  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(status_out) && $stable(data_out) && !tclk_en);
  // R4
  start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!quiet && (status_in == 4'hC || status_in == 4'hD || status_in == 4'hF)) |=> tclk_en);
  // R6
  sticky_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tclk_en && !quiet) |=> tclk_en);
  // R9
  halt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> (tclk_en && status_out == 4'hF));
endmodule

bind trace_port_ctl trace_port_ctl_chk #(.W(W)) i_chk (.*);

// File: tb/test_trace_port_ctl.sv
module test_trace_port_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] status_in = '0, data_in = '0;
  logic       quiet = 1'b0;
  logic [3:0] status_out, data_out;
  logic       tclk_en, halted;

  int vecs = 0, errs = 0;
  logic [3:0] e_st = '0, e_d = '0;
  logic       e_arm = 1'b0, e_en = 1'b0;

  always #5 clk = ~clk;

  trace_port_ctl i_trace_port_ctl (.*);

  function automatic logic start_code(input logic [3:0] s);
    return s == 4'hC || s == 4'hD || s == 4'hF;
  endfunction

  task automatic check(input string tag);
    vecs++;
    if (status_out !== e_st) begin errs++; $display("FAIL %s status_out got %h exp %h", tag, status_out, e_st); end
    if (data_out !== e_d) begin errs++; $display("FAIL %s data_out got %h exp %h", tag, data_out, e_d); end
    if (tclk_en !== e_en) begin errs++; $display("FAIL %s tclk_en got %b exp %b", tag, tclk_en, e_en); end
    if (halted !== (e_st == 4'hF)) begin errs++; $display("FAIL %s/R9 halted got %b exp %b", tag, halted, e_st == 4'hF); end
  endtask

  task automatic step(input logic [3:0] s, input logic [3:0] d, input logic q, input string tag);
    status_in = s; data_in = d; quiet = q;
    @(posedge clk);
    e_arm = e_arm | start_code(s);
    e_en  = !q && e_arm;
    if (!q) begin e_st = s; e_d = d; end
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset(input string tag);
    rst_n = 1'b0; status_in = 4'hF; data_in = 4'hA; quiet = 1'b0;
    repeat (2) @(posedge clk);
    e_st = '0; e_d = '0; e_arm = 1'b0; e_en = 1'b0;
    @(negedge clk);
    check(tag);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_500_000;
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset("R1");
    // R5: non-start codes show on status but clock stays off
    step(4'h1, 4'h3, 0, "R5");
    step(4'hE, 4'h7, 0, "R5");
    step(4'h5, 4'h9, 0, "R2/R3");
    // R8: start code under quiet arms but stays frozen
    step(4'hD, 4'h2, 1, "R7/R8");
    step(4'h0, 4'h4, 1, "R7");
    step(4'h1, 4'h6, 0, "R8");
    step(4'h2, 4'h8, 0, "R6");
    // R9 halt code
    step(4'hF, 4'h1, 0, "R9");
    step(4'hF, 4'h5, 1, "R9/R7");
    step(4'h3, 4'h5, 0, "R9");
    // R10: reset disarms
    do_reset("R10");
    step(4'h4, 4'h0, 0, "R10");
    step(4'hC, 4'hB, 0, "R4");
    step(4'h6, 4'hB, 0, "R6");
    do_reset("R10");
    step(4'hF, 4'h2, 0, "R4");
    do_reset("R1");
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] s;
      s = 4'($urandom_range(0, 11));
      if ($urandom_range(0, 40) == 0) s = 4'hC + 4'($urandom_range(0, 1)) + 4'($urandom_range(0, 1) * 2);
      step(s, 4'($urandom), ($urandom_range(0, 3) == 0), "R2/R3/R4/R6/R7");
      if ($urandom_range(0, 600) == 0) do_reset("R10");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule